// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

A synchronous binary counter with a two-bit operating mode: zero the count, step it down, take a parallel preset value, or step it up. All state changes happen on the rising clock edge. The one exception is a build option that zeroes the count the moment the clear mode is selected, without waiting for a clock. Stepping needs both active-low enables, P and T, to be low at the edge. Clear and preset ignore the enables.

An active-low carry output marks the terminal count for the current direction: all ones when counting up, zero when counting down. The carry is combinational and is qualified by T, and optionally by P as well. When the carry of one stage drives the T enable of the next, a chain of stages behaves as a single wide synchronous counter with no glue logic. A parameter selects whether P also gates the carry.

Top module: `updn_counter`

## Requirements
- R1: With mode = 2'b10 the count takes the value of `din` at the next rising edge, whatever the levels of both enables.
- R2: With mode = 2'b11 and both enables low, the count increases by one at each rising edge, and 255 is followed by 0.
- R3: With mode = 2'b01 and both enables low, the count decreases by one at each rising edge, and 0 is followed by 255.
- R4: In either stepping mode (2'b01 or 2'b11), the count keeps its value at a rising edge where P or T is high.
- R5: `carry_n` is low exactly when T is low and either mode = 2'b11 with the count at all ones, or mode = 2'b01 with the count at zero. In the clear mode (2'b00) and the preset mode (2'b10) it stays high.
- R6: With `CARRY_GATE_P` = 1, P high forces `carry_n` high. With `CARRY_GATE_P` = 0, P has no effect on `carry_n`.
- R7: With `ASYNC_CLEAR` = 1, selecting mode 2'b00 drives the count to zero before any clock edge.
- R8: With `ASYNC_CLEAR` = 0, mode 2'b00 leaves the count unchanged until the next rising edge, which zeroes it.
- R9: Apart from the asynchronous clear, a change of mode between edges leaves the count unchanged until the next rising edge.
- R10: Two stages, the low stage's `carry_n` wired to the high stage's T enable and all other inputs shared, count as one 16-bit counter. This covers 0xFFFF to 0x0000 going up and 0x0000 to 0xFFFF going down.
- R11: While `rst_n` is low the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 clear, 01 down, 10 preset, 11 up |
| din | input | WIDTH | Parallel preset value |
| en_p_n | input | 1 | Active-low count enable P |
| en_t_n | input | 1 | Active-low count enable T, cascade input |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The clocked properties assume that mode, data and enables change only between rising edges, never at an edge. The bench drives every input on the falling edge to stay inside that assumption. The hold, preset and stepping properties also take into account that an asynchronous clear can zero the count between two edges. The random stimulus therefore includes clear mode, and each step is checked once before and once after its edge, so the effect of an early clear is observed at the moment it happens.

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int WIDTH        = 8,
  parameter bit ASYNC_CLEAR  = 1'b1,
  parameter bit CARRY_GATE_P = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p_n,
  input  logic             en_t_n,
  output logic [WIDTH-1:0] count,
  output logic             carry_n
);
  localparam logic [1:0] M_CLR = 2'b00, M_DN = 2'b01, M_LD = 2'b10, M_UP = 2'b11;
  localparam logic [WIDTH-1:0] ALL1 = '1;

  logic [WIDTH-1:0] q, nxt;
  logic step, at_end, gate;

  assign step = ~en_p_n & ~en_t_n;

  always_comb begin
    case (mode)
      M_CLR:   nxt = '0;
      M_DN:    nxt = step ? q - 1'b1 : q;
      M_LD:    nxt = din;
      default: nxt = step ? q + 1'b1 : q;
    endcase
  end

  generate
    if (ASYNC_CLEAR) begin : g_aclr
      logic clr_now;
      assign clr_now = (mode == M_CLR);
      always_ff @(posedge clk or negedge rst_n or posedge clr_now)
        if (!rst_n)       q <= '0;
        else if (clr_now) q <= '0;
        else              q <= nxt;
    end else begin : g_sclr
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
  endgenerate

  assign at_end  = (mode == M_UP && q == ALL1) || (mode == M_DN && q == '0);
  assign gate    = ~en_t_n & (CARRY_GATE_P ? ~en_p_n : 1'b1);
  assign carry_n = ~(at_end & gate);
  assign count   = q;

  logic aclr_seen;
  assign aclr_seen = ASYNC_CLEAR && (mode == M_CLR);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LD) |=> (count == $past(din)) || aclr_seen);

  p_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UP && !en_p_n && !en_t_n) |=> (count == WIDTH'($past(count) + 1)) || aclr_seen);

  p_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DN && !en_p_n && !en_t_n) |=> (count == WIDTH'($past(count) - 1)) || aclr_seen);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && (en_p_n || en_t_n)) |=> (count == $past(count)) || aclr_seen);

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (!en_t_n && mode[0] && (count == '0 || count == ALL1)));

  p_carry_p_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (CARRY_GATE_P && en_p_n) |-> carry_n);

  p_aclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ASYNC_CLEAR && mode == M_CLR) |-> (count == '0));

  p_sclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CLR) |=> (count == '0));
endmodule

// File: tb/updn_counter_test.sv
`timescale 1ns/1ps
module updn_counter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  logic [1:0] m1 = 2'b11; logic [7:0] d1 = '0; logic p1 = 1'b1, t1 = 1'b1;
  logic [7:0] q1; logic c1;
  logic [7:0] e1 = '0;

  updn_counter #(.WIDTH(8), .ASYNC_CLEAR(1'b1), .CARRY_GATE_P(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode(m1), .din(d1), .en_p_n(p1), .en_t_n(t1),
    .count(q1), .carry_n(c1));

  logic [1:0] m2 = 2'b11; logic [15:0] d2 = '0; logic p2 = 1'b1, t2 = 1'b1;
  logic [7:0] qlo, qhi; logic clo, chi;
  logic [15:0] e2 = '0;

  updn_counter #(.WIDTH(8), .ASYNC_CLEAR(1'b0), .CARRY_GATE_P(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .mode(m2), .din(d2[7:0]), .en_p_n(p2), .en_t_n(t2),
    .count(qlo), .carry_n(clo));
  updn_counter #(.WIDTH(8), .ASYNC_CLEAR(1'b0), .CARRY_GATE_P(1'b0)) u_hi (
    .clk(clk), .rst_n(rst_n), .mode(m2), .din(d2[15:8]), .en_p_n(p2), .en_t_n(clo),
    .count(qhi), .carry_n(chi));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(logic [1:0] m, logic [15:0] c, logic [15:0] d,
                                      logic p, logic t, logic [15:0] msk);
    case (m)
      2'b00:   return '0;
      2'b01:   return (!p && !t) ? ((c - 1) & msk) : c;
      2'b10:   return d & msk;
      default: return (!p && !t) ? ((c + 1) & msk) : c;
    endcase
  endfunction

  function automatic logic cry(logic [1:0] m, logic [15:0] c, logic p, logic t,
                               logic gp, logic [15:0] msk);
    logic term;
    term = (m == 2'b11 && c == msk) || (m == 2'b01 && c == 16'h0);
    return !(term && !t && (gp ? !p : 1'b1));
  endfunction

  // single stage, async clear, carry gated by P and T
  task automatic drv1(logic [1:0] m, logic [7:0] d, logic p, logic t, string req);
    @(negedge clk);
    m1 = m; d1 = d; p1 = p; t1 = t;
    if (m == 2'b00) e1 = '0;
    #1;
    chk(m == 2'b00 ? "R7 async clear" : "R9 no change before edge", {8'h0, q1}, {8'h0, e1});
    chk("R5/R6 carry", {15'h0, c1}, {15'h0, cry(m, {8'h0, e1}, p, t, 1'b1, 16'hFF)});
    @(posedge clk); #1;
    e1 = nxt(m, {8'h0, e1}, {8'h0, d}, p, t, 16'hFF);
    chk(req, {8'h0, q1}, {8'h0, e1});
  endtask

  // two-stage chain, sync clear, carry gated by T only
  task automatic drv2(logic [1:0] m, logic [15:0] d, logic p, logic t, string req);
    @(negedge clk);
    m2 = m; d2 = d; p2 = p; t2 = t;
    #1;
    chk(m == 2'b00 ? "R8 sync clear waits" : "R9 no change before edge", {qhi, qlo}, e2);
    chk("R10/R6 chain carry", {15'h0, chi}, {15'h0, cry(m, e2, p, t, 1'b0, 16'hFFFF)});
    @(posedge clk); #1;
    e2 = nxt(m, e2, d, p, t, 16'hFFFF);
    chk(req, {qhi, qlo}, e2);
  endtask

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #7;
    chk("R11 reset single", {8'h0, q1}, 16'h0);
    chk("R11 reset chain", {qhi, qlo}, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // preset 252, count up through wrap, back down
    drv1(2'b10, 8'd252, 1'b1, 1'b1, "R1 preset ignores enables");
    for (int i = 0; i < 6; i++) drv1(2'b11, 8'h00, 1'b0, 1'b0, "R2 up wrap");
    chk("R2 end value", {8'h0, q1}, 16'd2);
    for (int i = 0; i < 6; i++) drv1(2'b01, 8'h00, 1'b0, 1'b0, "R3 down wrap");
    chk("R3 end value", {8'h0, q1}, 16'd252);
    drv1(2'b11, 8'h00, 1'b1, 1'b0, "R4 hold P high");
    drv1(2'b01, 8'h00, 1'b0, 1'b1, "R4 hold T high");
    drv1(2'b10, 8'hFF, 1'b0, 1'b0, "R1 preset ff");
    drv1(2'b11, 8'h00, 1'b1, 1'b0, "R6 P high blocks carry and step");
    drv1(2'b10, 8'hFF, 1'b0, 1'b0, "R5 preset mode carry high");
    drv1(2'b00, 8'h55, 1'b0, 1'b0, "R7 clear");
    drv1(2'b01, 8'h00, 1'b0, 1'b0, "R3 0 to 255");

    for (int i = 0; i < 500; i++) begin
      logic [1:0] m;
      m = ($urandom % 10 == 0) ? 2'b00 : 2'($urandom);
      drv1(m, 8'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0), "R1-random single");
      if ($urandom % 16 == 0) drv1(2'b10, ($urandom % 2) ? 8'hFF : 8'h00, 1'b1, 1'b1, "R1 corner preset");
    end

    // chain: 16-bit wraps, T-only carry, sync clear, mode change mid-run
    drv2(2'b10, 16'hFFFD, 1'b1, 1'b1, "R10 preset");
    for (int i = 0; i < 4; i++) drv2(2'b11, 16'h0, 1'b0, 1'b0, "R10 up wrap");
    chk("R10 up end", {qhi, qlo}, 16'h0001);
    for (int i = 0; i < 3; i++) drv2(2'b01, 16'h0, 1'b0, 1'b0, "R10 down wrap");
    chk("R10 down end", {qhi, qlo}, 16'hFFFE);
    drv2(2'b11, 16'h0, 1'b0, 1'b0, "R10 to ffff");
    drv2(2'b11, 16'h0, 1'b1, 1'b0, "R6 P ignored by carry, R4 hold");
    drv2(2'b10, 16'h00FF, 1'b0, 1'b0, "R10 mode change to preset");
    drv2(2'b11, 16'h0, 1'b0, 1'b0, "R10 byte carry");
    chk("R10 carry into high", {qhi, qlo}, 16'h0100);
    drv2(2'b00, 16'h1234, 1'b1, 1'b1, "R8 sync clear");

    for (int i = 0; i < 600; i++) begin
      logic [1:0] m;
      m = ($urandom % 12 == 0) ? 2'b00 : 2'($urandom);
      drv2(m, ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom),
           1'($urandom % 5 == 0), 1'($urandom % 5 == 0), "R10 random chain");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule